// File: doc/BRIEF.md
# Dual-Framing Serial Command Receiver

This block is the slave-side serial front end of a display controller. A host clocks words in on SCL and SDA while it holds an active-low chip select low. The block rebuilds each word in the system clock domain and hands it onward as an 8-bit value, a flag that marks it as a command or a parameter, and a one-cycle valid strobe.

A static framing pin selects one of two formats. With the pin low, each word is 8 bits and a separate data/command pin gives the tag. With the pin high there is no tag pin: each word is 9 bits and its leading bit carries the tag. SCL, chip select, SDA and the tag pin pass through a two-flop synchronizer before use, so SCL must run several times slower than the system clock.

The bidirectional SDA line is split into an input, an output value and an output enable. When the downstream command decoder raises `rd_active`, the block shifts a supplied read byte back to the host, one bit per SCL period, MSB first.

Top module: `serial_cmd_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rx_valid` and `sda_oe` are 0.
- R2: With `mode_3w` = 0, eight bits are taken MSB first on rising SCL edges. `rx_is_data` equals the level of `dc` at the eighth edge: 1 marks a parameter and 0 marks a command.
- R3: With `mode_3w` = 1, nine bits are taken on rising SCL edges. The first bit is the tag (1 = parameter, 0 = command) and the next eight form `rx_byte`, MSB first.
- R4: While `csn` is high, SCL edges are ignored. A word cut off by `csn` rising is discarded and the bit count restarts at zero.
- R5: Each completed word gives exactly one `rx_valid` pulse, one clock long, within 6 clock cycles of the final SCL rising edge.
- R6: Several words may follow back to back in one chip-select frame, and each is delivered in order.
- R7: While `rd_active` is 1 and `csn` is low, `sda_oe` is 1 and `sda_out` presents `rd_byte` MSB first, one bit per SCL period, stable before each rising edge. In 9-bit framing the first slot carries 0. No `rx_valid` pulse is produced.
- R8: `sda_oe` is 0 whenever `csn` is high or `rd_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_3w | input | 1 | Framing select: 0 = 8-bit words with tag pin, 1 = 9-bit words with inline tag |
| csn | input | 1 | Chip select, active low |
| scl | input | 1 | Serial clock from host |
| sdi | input | 1 | SDA input level |
| dc | input | 1 | Data/command tag pin (8-bit framing only) |
| rd_active | input | 1 | Current transfer is a read |
| rd_byte | input | DATA_W | Byte to return to the host |
| sda_out | output | 1 | SDA output value |
| sda_oe | output | 1 | SDA output enable |
| rx_byte | output | DATA_W | Received word value |
| rx_is_data | output | 1 | Tag of the received word: 1 parameter, 0 command |
| rx_valid | output | 1 | One-cycle strobe for a completed word |

## Verification
The hardest case to reach is a word that chip select cuts off partway, because a stale bit count only shows up in the word that follows. The bench raises chip select after a few bits, pulses SCL while deselected, and then sends a full word in a new frame. That word must arrive whole, with no extra strobe from the fragment. The main sweep sends every byte value with both tags in both framings inside a single long frame per framing. Read-back samples `sda_out` just before each rising SCL edge.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic {
    FRAME_TAGPIN = 1'b0,
    FRAME_INLINE = 1'b1
  } frame_e;

  // bits per word for a given framing
  function automatic int word_bits(input frame_e f, input int data_w);
    return (f == FRAME_INLINE) ? data_w + 1 : data_w;
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  frame_e            frame,
  input  logic              cs_act,
  input  logic              bit_stb,
  input  logic              sdi,
  input  logic              dc,
  input  logic              hold,
  output logic [CW-1:0]     cnt,
  output logic [DATA_W-1:0] word,
  output logic              is_data,
  output logic              valid
);
  localparam logic [CW-1:0] LAST_PIN = CW'(word_bits(FRAME_TAGPIN, DATA_W) - 1);
  localparam logic [CW-1:0] LAST_INL = CW'(word_bits(FRAME_INLINE, DATA_W) - 1);

  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     last_idx;
  logic              at_last;

  assign last_idx = (frame == FRAME_INLINE) ? LAST_INL : LAST_PIN;
  assign at_last  = (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      cnt   <= '0;
      shreg <= '0;
      valid <= 1'b0;
      if (rst) begin
        word    <= '0;
        is_data <= 1'b0;
      end
    end else begin
      valid <= 1'b0;
      if (bit_stb) begin
        shreg <= {shreg[DATA_W-2:0], sdi};
        if (at_last) begin
          cnt <= '0;
          if (!hold) begin
            valid   <= 1'b1;
            word    <= {shreg[DATA_W-2:0], sdi};
            is_data <= (frame == FRAME_INLINE) ? shreg[DATA_W-1] : dc;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: deselect forces the word state idle on the next cycle
  a_r4_deselect_clears: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (cnt == '0) && !valid);
  // R3: the bit count never passes the last slot of the word
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_idx);
  // R5: a strobe never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/srx_readback.sv
module srx_readback
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  frame_e            frame,
  input  logic              cs_act,
  input  logic              rd_active,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic [CW-1:0]     cnt,
  output logic              sda_out,
  output logic              sda_oe
);
  logic [CW-1:0]     pos;
  logic [DATA_W-1:0] shifted;
  logic              nxt_bit;

  always_comb begin
    pos     = '0;
    nxt_bit = 1'b0;
    if (frame == FRAME_INLINE) begin
      pos = CW'(DATA_W) - cnt;
      if (cnt != '0) begin
        shifted = rd_byte >> pos;
        nxt_bit = shifted[0];
      end else begin
        shifted = '0;
      end
    end else begin
      pos     = CW'(DATA_W - 1) - cnt;
      shifted = rd_byte >> pos;
      nxt_bit = shifted[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_out <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      sda_out <= nxt_bit & rd_active & cs_act;
      sda_oe  <= rd_active & cs_act;
    end
  end

  // R8: the output enable drops after deselect or end of read
  a_r8_oe_release: assert property (@(posedge clk) disable iff (rst)
    (!cs_act || !rd_active) |=> !sda_oe);
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_3w,
  input  logic              csn,
  input  logic              scl,
  input  logic              sdi,
  input  logic              dc,
  input  logic              rd_active,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              sda_out,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_is_data,
  output logic              rx_valid
);
  // bus order: {scl, csn, sdi, dc}; csn idles high
  logic [3:0] raw_bus, sync_bus;
  logic       scl_s, csn_s, sdi_s, dc_s, scl_q;
  logic       cs_act, bit_stb;
  logic [CW-1:0] cnt;
  frame_e     frame;

  assign raw_bus = {scl, csn, sdi, dc};
  assign frame   = frame_e'(mode_3w);

  srx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus)
  );

  assign {scl_s, csn_s, sdi_s, dc_s} = sync_bus;

  always_ff @(posedge clk) begin
    if (rst) scl_q <= 1'b0;
    else     scl_q <= scl_s;
  end

  assign cs_act  = !csn_s;
  assign bit_stb = scl_s & !scl_q & cs_act;

  srx_deser #(.DATA_W(DATA_W)) u_deser (
    .clk(clk), .rst(rst), .frame(frame), .cs_act(cs_act),
    .bit_stb(bit_stb), .sdi(sdi_s), .dc(dc_s), .hold(rd_active),
    .cnt(cnt), .word(rx_byte), .is_data(rx_is_data), .valid(rx_valid)
  );

  srx_readback #(.DATA_W(DATA_W)) u_rdbk (
    .clk(clk), .rst(rst), .frame(frame), .cs_act(cs_act),
    .rd_active(rd_active), .rd_byte(rd_byte), .cnt(cnt),
    .sda_out(sda_out), .sda_oe(sda_oe)
  );

  // R7: a read cycle produces no strobe
  a_r7_no_strobe_on_read: assert property (@(posedge clk) disable iff (rst)
    rd_active |=> !rx_valid);
  // R1: outputs idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> !rx_valid && !sda_oe);
endmodule

// File: tb/tb_serial_cmd_rx.sv
module tb_serial_cmd_rx;
  localparam int HALF = 5;

  logic clk = 0, rst = 1;
  logic mode_3w = 0, csn = 1, scl = 0, sdi = 0, dc = 0, rd_active = 0;
  logic [7:0] rd_byte = '0;
  logic sda_out, sda_oe, rx_is_data, rx_valid;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, cycles = 0;
  int cap_n = 0, dbl = 0;
  logic [7:0] cap_byte;
  logic cap_tag, prev_v = 0;
  logic done = 0;

  serial_cmd_rx dut (
    .clk(clk), .rst(rst), .mode_3w(mode_3w), .csn(csn), .scl(scl), .sdi(sdi),
    .dc(dc), .rd_active(rd_active), .rd_byte(rd_byte), .sda_out(sda_out),
    .sda_oe(sda_oe), .rx_byte(rx_byte), .rx_is_data(rx_is_data), .rx_valid(rx_valid)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (rx_valid) begin
      cap_n++;
      cap_byte = rx_byte;
      cap_tag = rx_is_data;
      if (prev_v) dbl++;
    end
    prev_v = rx_valid;
  end

  initial begin
    while (cycles < 200000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL period; returns sda_out sampled just before the rising edge
  task automatic clock_bit(input logic b, output logic rb);
    sdi = b;
    scl = 0;
    wait_clk(HALF);
    rb = sda_out;
    scl = 1;
    wait_clk(HALF);
    scl = 0;
  endtask

  task automatic send_word(input logic tag, input logic [7:0] v);
    logic rb;
    dc = tag;
    if (mode_3w) clock_bit(tag, rb);
    for (int i = 7; i >= 0; i--) clock_bit(v[i], rb);
  endtask

  task automatic frame_start();
    csn = 0;
    wait_clk(HALF);
  endtask

  task automatic frame_end();
    wait_clk(HALF);
    csn = 1;
    wait_clk(HALF);
  endtask

  task automatic sweep(input logic m);
    int base;
    mode_3w = m;
    frame_start();
    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < 256; b++) begin
        base = cap_n;
        send_word(t[0], b[7:0]);
        if (m) chk(cap_n == base + 1 && cap_byte == b[7:0] && cap_tag == t[0],
                   "R3 inline word", {cap_tag, cap_byte}, {t[0], b[7:0]});
        else   chk(cap_n == base + 1 && cap_byte == b[7:0] && cap_tag == t[0],
                   "R2 tag-pin word", {cap_tag, cap_byte}, {t[0], b[7:0]});
      end
    end
    frame_end();
  endtask

  task automatic read_back(input logic m, input logic [7:0] v);
    logic rb;
    logic [8:0] got;
    int base;
    mode_3w = m;
    rd_byte = v;
    rd_active = 1;
    base = cap_n;
    frame_start();
    wait_clk(HALF);
    chk(sda_oe == 1, "R7 oe during read", sda_oe, 1);
    got = '0;
    for (int i = 0; i < (m ? 9 : 8); i++) begin
      clock_bit(1'b1, rb);
      got = {got[7:0], rb};
    end
    if (m) chk(got == {1'b0, v}, "R7 inline read bits", got, {1'b0, v});
    else   chk(got[7:0] == v, "R7 tag-pin read bits", got[7:0], v);
    wait_clk(HALF);
    chk(cap_n == base, "R7 no strobe in read", cap_n - base, 0);
    frame_end();
    rd_active = 0;
    wait_clk(4);
    chk(sda_oe == 0, "R8 oe after deselect", sda_oe, 0);
  endtask

  initial begin
    logic rb;
    int base;
    wait_clk(3);
    chk(rx_valid == 0 && sda_oe == 0, "R1 in reset", {rx_valid, sda_oe}, 0);
    rst = 0;
    @(negedge clk);
    chk(rx_valid == 0 && sda_oe == 0, "R1 after reset", {rx_valid, sda_oe}, 0);
    wait_clk(4);

    // R2 / R3 / R6: exhaustive sweeps, back to back in one frame per framing
    sweep(1'b0);
    sweep(1'b1);

    // R5: strobe timing on a single word
    mode_3w = 0;
    frame_start();
    base = cap_n;
    dc = 0;
    for (int i = 7; i >= 1; i--) clock_bit(i[0], rb);
    sdi = 1;
    scl = 0;
    wait_clk(HALF);
    scl = 1;
    wait_clk(6);
    chk(cap_n == base + 1, "R5 strobe within window", cap_n - base, 1);
    chk(dbl == 0, "R5 single cycle strobe", dbl, 0);
    scl = 0;
    frame_end();

    // R4: cut-off word, then SCL while deselected, then a full word
    for (int m = 0; m < 2; m++) begin
      mode_3w = m[0];
      base = cap_n;
      frame_start();
      for (int i = 0; i < 5; i++) clock_bit(1'b1, rb);
      frame_end();
      for (int i = 0; i < 9; i++) clock_bit(1'b0, rb);
      chk(cap_n == base, "R4 partial word dropped", cap_n - base, 0);
      frame_start();
      send_word(1'b1, 8'h81);
      frame_end();
      chk(cap_n == base + 1 && cap_byte == 8'h81 && cap_tag == 1,
          "R4 count restarts", {cap_tag, cap_byte}, 9'h181);
    end

    // R8: idle enable
    chk(sda_oe == 0, "R8 oe idle", sda_oe, 0);
    rd_active = 1;
    wait_clk(4);
    chk(sda_oe == 0, "R8 oe with csn high", sda_oe, 0);
    rd_active = 0;

    // R7: read-back in both framings
    read_back(1'b0, 8'hA5);
    read_back(1'b0, 8'h3C);
    read_back(1'b1, 8'h3C);
    read_back(1'b1, 8'hC3);

    chk(dbl == 0, "R5 no double strobe over run", dbl, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule